// File: doc/BRIEF.md
# GPIO Pad Configuration Controller

This block sits beside one I/O pad and turns a stored configuration word into the control signals the pad needs. The word chooses which side owns the pad (the management side or the user side), carries an output-disable bit, and carries a three-bit drive-mode field that goes to the pad unchanged. The pad output, the output-disable and the input path then follow the owner and the word. The field stays passed through even where this block also reads it.

The pad has no separate pull resistors. A weak pull is made by enabling the output driver, which reaches the pad through a series resistor, and driving it to a fixed level. When the drive mode asks for a pull-up or a pull-down, the block forces the pad output level for either owner, whatever that owner drives. The output-disable is never forced: software must clear the output-disable bit for a pull to work. The pad input always reaches the user side, even when the management side owns the pad. The configuration word loads through a synchronous write strobe. Every pad-facing output is registered.

Top module: `pad_cfg_ctrl`

## Requirements
- R1: While `rst` is high, the configuration word takes the value 0x0403: management owner, output-disable set, drive mode 001. The outputs read `pad_dm`=001, `pad_oeb`=1, `pad_out`=0, `mgmt_in`=0 and `user_in`=0.
- R2: The configuration word takes `cfg_wdata` on a rising edge where `cfg_we` is 1. It keeps its value on any edge where `cfg_we` is 0.
- R3: `pad_dm` equals bits 12:10 of the configuration word.
- R4: Bit 0 of the word picks the owner, 1 for management and 0 for user. Outside the pull modes, `pad_out` follows the owner's output. When bit 1 is 0, `pad_oeb` follows the owner's output-disable.
- R5: When bit 1 of the word is 1, `pad_oeb` is 1 whatever the owner drives.
- R6: When the drive mode is 011 (pull-up), `pad_out` is 1 under either owner, whatever the owner's output is.
- R7: When the drive mode is 010 (pull-down), `pad_out` is 0 under either owner, whatever the owner's output is.
- R8: In the pull modes, `pad_oeb` is not forced. It is bit 1 ORed with the owner's output-disable, the same rule as outside those modes.
- R9: `user_in` follows `pad_in` under either owner. `mgmt_in` follows `pad_in` under management ownership and is 0 under user ownership.
- R10: Every output is registered. A change on any input or on the configuration word shows on the outputs after the next rising edge, and not before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 13 | Configuration word to load |
| mgmt_out | input | 1 | Management output level |
| mgmt_oeb | input | 1 | Management output disable (active high) |
| user_out | input | 1 | User output level |
| user_oeb | input | 1 | User output disable (active high) |
| pad_in | input | 1 | Level received from the pad |
| pad_dm | output | 3 | Drive-mode field sent to the pad |
| pad_oeb | output | 1 | Output disable sent to the pad |
| pad_out | output | 1 | Output level sent to the pad |
| mgmt_in | output | 1 | Pad input routed to management |
| user_in | output | 1 | Pad input routed to user logic |

## Verification
On every cycle, the assertions check that the word loads or holds, that `pad_dm` and `user_in` follow one cycle later, and that a pull mode forces the level. They also check that a set output-disable bit forces the disable, and that the owner's disable passes through when that bit is clear. Only the bench's scenarios can show the four standard pull encodings under each owner with both output levels and both disable levels. Only they can show that an input change does not reach the outputs before the clock edge, and how randomly chosen words and input mixes combine.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
  localparam int unsigned CFG_W      = 13;
  localparam int unsigned DM_W       = 3;
  localparam int unsigned DM_LSB     = 10;
  localparam int unsigned OWNER_BIT  = 0;
  localparam int unsigned OEB_BIT    = 1;
  localparam logic [DM_W-1:0] DM_PULL_DOWN = 3'b010;
  localparam logic [DM_W-1:0] DM_PULL_UP   = 3'b011;

  typedef enum logic {
    OWNER_USER = 1'b0,
    OWNER_MGMT = 1'b1
  } pad_owner_e;

  typedef enum logic [1:0] {
    PULL_NONE = 2'd0,
    PULL_LOW  = 2'd1,
    PULL_HIGH = 2'd2
  } pull_kind_e;

  function automatic pull_kind_e decode_pull(input logic [DM_W-1:0] dm);
    if (dm == DM_PULL_UP)        return PULL_HIGH;
    else if (dm == DM_PULL_DOWN) return PULL_LOW;
    else                         return PULL_NONE;
  endfunction
endpackage

// File: rtl/pcc_cfg_reg.sv
module pcc_cfg_reg #(
  parameter int unsigned CFG_W = 13,
  parameter logic [CFG_W-1:0] RST_CFG = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [CFG_W-1:0] wdata,
  output logic [CFG_W-1:0] cfg_q
);
  always_ff @(posedge clk) begin
    if (rst)     cfg_q <= RST_CFG;
    else if (we) cfg_q <= wdata;
  end

  assert_reset_value_R1: assert property (@(posedge clk)
    rst |=> cfg_q == RST_CFG);
  assert_load_R2: assert property (@(posedge clk) disable iff (rst)
    we |=> cfg_q == $past(wdata));
  assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
    !we |=> $stable(cfg_q));
endmodule

// File: rtl/pcc_pad_mux.sv
module pcc_pad_mux
  import pcc_pkg::*;
#(
  parameter int unsigned CFG_W = 13
) (
  input  logic [CFG_W-1:0] cfg,
  input  logic             mgmt_out,
  input  logic             mgmt_oeb,
  input  logic             user_out,
  input  logic             user_oeb,
  input  logic             pad_in,
  output logic [DM_W-1:0]  nxt_dm,
  output logic             nxt_oeb,
  output logic             nxt_out,
  output logic             nxt_mgmt_in,
  output logic             nxt_user_in
);
  pad_owner_e owner;
  pull_kind_e pull;
  logic       sel_out;
  logic       sel_oeb;

  always_comb begin
    owner  = pad_owner_e'(cfg[OWNER_BIT]);
    nxt_dm = cfg[DM_LSB +: DM_W];
    pull   = decode_pull(nxt_dm);
    if (owner == OWNER_MGMT) begin
      sel_out = mgmt_out;
      sel_oeb = mgmt_oeb;
    end else begin
      sel_out = user_out;
      sel_oeb = user_oeb;
    end
    // Output-disable is a plain configuration bit: pulls never touch it.
    nxt_oeb = cfg[OEB_BIT] | sel_oeb;
    case (pull)
      PULL_HIGH: nxt_out = 1'b1;
      PULL_LOW:  nxt_out = 1'b0;
      default:   nxt_out = sel_out;
    endcase
    nxt_user_in = pad_in;
    nxt_mgmt_in = (owner == OWNER_MGMT) ? pad_in : 1'b0;
  end
endmodule

// File: rtl/pcc_out_stage.sv
module pcc_out_stage
  import pcc_pkg::*;
#(
  parameter logic [DM_W-1:0] RST_DM = 3'b001
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [DM_W-1:0] nxt_dm,
  input  logic            nxt_oeb,
  input  logic            nxt_out,
  input  logic            nxt_mgmt_in,
  input  logic            nxt_user_in,
  output logic [DM_W-1:0] pad_dm,
  output logic            pad_oeb,
  output logic            pad_out,
  output logic            mgmt_in,
  output logic            user_in
);
  always_ff @(posedge clk) begin
    if (rst) begin
      pad_dm  <= RST_DM;
      pad_oeb <= 1'b1;
      pad_out <= 1'b0;
      mgmt_in <= 1'b0;
      user_in <= 1'b0;
    end else begin
      pad_dm  <= nxt_dm;
      pad_oeb <= nxt_oeb;
      pad_out <= nxt_out;
      mgmt_in <= nxt_mgmt_in;
      user_in <= nxt_user_in;
    end
  end
endmodule

// File: rtl/pad_cfg_ctrl.sv
module pad_cfg_ctrl
  import pcc_pkg::*;
#(
  parameter logic [CFG_W-1:0] RST_CFG = 13'h0403
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [CFG_W-1:0] cfg_wdata,
  input  logic             mgmt_out,
  input  logic             mgmt_oeb,
  input  logic             user_out,
  input  logic             user_oeb,
  input  logic             pad_in,
  output logic [DM_W-1:0]  pad_dm,
  output logic             pad_oeb,
  output logic             pad_out,
  output logic             mgmt_in,
  output logic             user_in
);
  localparam logic [DM_W-1:0] RST_DM = RST_CFG[DM_LSB +: DM_W];

  logic [CFG_W-1:0] cfg_q;
  logic [DM_W-1:0]  nxt_dm;
  logic             nxt_oeb, nxt_out, nxt_mgmt_in, nxt_user_in;

  pcc_cfg_reg #(.CFG_W(CFG_W), .RST_CFG(RST_CFG)) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_wdata), .cfg_q(cfg_q)
  );

  pcc_pad_mux #(.CFG_W(CFG_W)) u_mux (
    .cfg(cfg_q), .mgmt_out(mgmt_out), .mgmt_oeb(mgmt_oeb),
    .user_out(user_out), .user_oeb(user_oeb), .pad_in(pad_in),
    .nxt_dm(nxt_dm), .nxt_oeb(nxt_oeb), .nxt_out(nxt_out),
    .nxt_mgmt_in(nxt_mgmt_in), .nxt_user_in(nxt_user_in)
  );

  pcc_out_stage #(.RST_DM(RST_DM)) u_out (
    .clk(clk), .rst(rst),
    .nxt_dm(nxt_dm), .nxt_oeb(nxt_oeb), .nxt_out(nxt_out),
    .nxt_mgmt_in(nxt_mgmt_in), .nxt_user_in(nxt_user_in),
    .pad_dm(pad_dm), .pad_oeb(pad_oeb), .pad_out(pad_out),
    .mgmt_in(mgmt_in), .user_in(user_in)
  );

  // Configuration word against pad outputs, one registered cycle apart.
  assert_dm_pass_R3: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> pad_dm == $past(cfg_q[DM_LSB +: DM_W]));
  assert_pull_up_R6: assert property (@(posedge clk) disable iff (rst)
    cfg_q[DM_LSB +: DM_W] == DM_PULL_UP |=> pad_out);
  assert_pull_down_R7: assert property (@(posedge clk) disable iff (rst)
    cfg_q[DM_LSB +: DM_W] == DM_PULL_DOWN |=> !pad_out);
  assert_oeb_forced_R5: assert property (@(posedge clk) disable iff (rst)
    cfg_q[OEB_BIT] |=> pad_oeb);
  assert_oeb_mgmt_R8: assert property (@(posedge clk) disable iff (rst)
    (!cfg_q[OEB_BIT] && cfg_q[OWNER_BIT]) |=> pad_oeb == $past(mgmt_oeb));
  assert_oeb_user_R8: assert property (@(posedge clk) disable iff (rst)
    (!cfg_q[OEB_BIT] && !cfg_q[OWNER_BIT]) |=> pad_oeb == $past(user_oeb));
  assert_user_in_R9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> user_in == $past(pad_in));
  assert_mgmt_in_user_R9: assert property (@(posedge clk) disable iff (rst)
    !cfg_q[OWNER_BIT] |=> !mgmt_in);
endmodule

// File: tb/pad_cfg_ctrl_bench.sv
module pad_cfg_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [12:0] cfg_wdata = '0;
  logic        mgmt_out = 1'b0, mgmt_oeb = 1'b0, user_out = 1'b0, user_oeb = 1'b0;
  logic        pad_in = 1'b0;
  logic [2:0]  pad_dm;
  logic        pad_oeb, pad_out, mgmt_in, user_in;

  int n_checks = 0;
  int n_fail = 0;
  logic [12:0] cur_cfg;

  typedef struct packed {
    logic [2:0] dm;
    logic       oeb;
    logic       out;
    logic       m_in;
    logic       u_in;
  } exp_t;

  always #2.5 clk = ~clk;

  pad_cfg_ctrl u_pad_cfg_ctrl (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .mgmt_out(mgmt_out), .mgmt_oeb(mgmt_oeb), .user_out(user_out),
    .user_oeb(user_oeb), .pad_in(pad_in), .pad_dm(pad_dm),
    .pad_oeb(pad_oeb), .pad_out(pad_out), .mgmt_in(mgmt_in), .user_in(user_in)
  );

  function automatic exp_t model(input logic [12:0] c, input logic mo, input logic moe,
                                 input logic uo, input logic uoe, input logic pi);
    exp_t e;
    logic own;
    own    = c[0];
    e.dm   = c[12:10];
    e.oeb  = c[1] | (own ? moe : uoe);
    if (c[12:10] == 3'b011)      e.out = 1'b1;
    else if (c[12:10] == 3'b010) e.out = 1'b0;
    else                         e.out = own ? mo : uo;
    e.u_in = pi;
    e.m_in = own ? pi : 1'b0;
    return e;
  endfunction

  task automatic chk(input string req, input logic [3:0] act, input logic [3:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: cfg=%h actual=%h expected=%h", req, cur_cfg, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [12:0] c);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = c;
    @(negedge clk);
    cfg_we = 1'b0;
    cur_cfg = c;
  endtask

  task automatic compare_all;
    exp_t e;
    string tout, toeb;
    e = model(cur_cfg, mgmt_out, mgmt_oeb, user_out, user_oeb, pad_in);
    tout = (cur_cfg[12:10] == 3'b011) ? "R6" : (cur_cfg[12:10] == 3'b010) ? "R7" : "R4";
    toeb = cur_cfg[1] ? "R5" : (cur_cfg[12:11] == 2'b01) ? "R8" : "R4";
    chk("R3 pad_dm", {1'b0, pad_dm}, {1'b0, e.dm});
    chk(tout, {3'b0, pad_out}, {3'b0, e.out});
    chk(toeb, {3'b0, pad_oeb}, {3'b0, e.oeb});
    chk("R9 inputs", {2'b0, mgmt_in, user_in}, {2'b0, e.m_in, e.u_in});
  endtask

  // Inputs are driven at a falling edge; one rising edge later the outputs are sampled.
  task automatic drive_and_check(input logic mo, input logic moe, input logic uo,
                                 input logic uoe, input logic pi);
    mgmt_out = mo; mgmt_oeb = moe; user_out = uo; user_oeb = uoe; pad_in = pi;
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    #(200000 * 5);
    n_fail++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [12:0] enc [4];
    logic [31:0] seed;
    enc[0] = 13'h0801; enc[1] = 13'h0c01; enc[2] = 13'h0800; enc[3] = 13'h0c00;
    seed = $urandom(32'd1234);
    cur_cfg = 13'h0403;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk("R1 pad_dm", {1'b0, pad_dm}, 4'b0001);
    chk("R1 oeb/out", {2'b0, pad_oeb, pad_out}, 4'b0010);
    chk("R1 inputs", {2'b0, mgmt_in, user_in}, 4'b0000);
    rst = 1'b0;
    @(negedge clk);
    drive_and_check(1'b1, 1'b0, 1'b1, 1'b0, 1'b1);

    // R6/R7/R8: standard pull encodings, both owners, all owner output patterns
    foreach (enc[i]) begin
      write_cfg(enc[i]);
      for (int k = 0; k < 16; k++)
        drive_and_check(k[0], k[1], k[2], k[3], k[0] ^ k[2]);
    end

    // R5: pull mode with output-disable bit set keeps the disable high
    write_cfg(13'h0c03);
    drive_and_check(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    write_cfg(13'h0802);
    drive_and_check(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);

    // R4: plain owner selection, no pull
    write_cfg(13'h1801);
    drive_and_check(1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
    write_cfg(13'h1800);
    drive_and_check(1'b1, 1'b0, 1'b0, 1'b1, 1'b1);

    // R2: word held while the strobe is low
    @(negedge clk);
    cfg_wdata = 13'h0c03;
    repeat (2) @(negedge clk);
    chk("R2 hold", {1'b0, pad_dm}, 4'b0110);

    // R10: an input change is not visible before the next rising edge
    write_cfg(13'h0001);
    drive_and_check(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    mgmt_out = 1'b1; pad_in = 1'b1;
    #1;
    chk("R10 out before edge", {2'b0, pad_out, user_in}, 4'b0000);
    @(negedge clk);
    chk("R10 out after edge", {2'b0, pad_out, user_in}, 4'b0011);

    // Random words and inputs
    for (int n = 0; n < 300; n++) begin
      write_cfg(13'($urandom));
      drive_and_check(1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    end

    // R1: reset again from a non-default word
    write_cfg(13'h0c00);
    @(negedge clk);
    rst = 1'b1;
    repeat (2) @(negedge clk);
    cur_cfg = 13'h0403;
    chk("R1 re-reset", {pad_dm, pad_oeb}, 4'b0011);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 word after reset", {1'b0, pad_dm}, 4'b0001);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule